// File: doc/BRIEF.md
# Two-Stage Serial Clock Prescaler

This block derives the serial clock timing of a synchronous serial master from the core clock. It reads an 8-bit packed prescale byte from configuration and, depending on a mode select, interprets it either as a mantissa times a power of two (extended encoding) or as an offset-coded even divisor (legacy encoding). While the run input is high, it emits single-cycle strobes that mark each rising and each falling edge of the serial clock. The shift engine uses these strobes to launch and capture data. It also exposes the current clock level.

Internally a sequencer with three states does the counting. The states are IDLE, LOW_HALF and HIGH_HALF. The transitions are:
- START: IDLE to LOW_HALF, taken when run is sampled high. The divisor is latched at this point.
- RISE: LOW_HALF to HIGH_HALF, taken when the low-half count expires.
- FALL: HIGH_HALF to LOW_HALF, taken when the high-half count expires.
- HALT: any state to IDLE, taken whenever run is sampled low.

The divisor is latched only on START. A new prescale value therefore applies from the next transfer onward. Turning a requested bit rate into a prescale byte is a software task.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: After reset, rise_stb, fall_stb and sclk_lvl are all low.
- R2: With legacy_mode low, the divisor is M × 2^E. M is presc[3:0]. E is a 3-bit exponent whose bit 0 comes from presc[4] and whose bits 2:1 come from presc[7:6]. presc[5] has no effect. The largest divisor is 1920 (byte 0xDF).
- R3: In extended encoding, M = 0 is used as M = 1, and any resulting divisor below 2 is raised to 2. As examples, byte 0x00 gives divisor 2 and byte 0x10 gives divisor 2.
- R4: With legacy_mode high, let F = presc[4:0]. The divisor is 2 × (F − 16), which is at most 30. presc[7:5] have no effect.
- R5: In legacy encoding, any F below 0x12 gives divisor 4.
- R6: While run is low, neither strobe is asserted. From the cycle after run is sampled low, sclk_lvl is low.
- R7: Count the clock edges after the edge that first samples run high. The first rise_stb is asserted in the cycle that follows edge number floor(D/2).
- R8: The interval from rise_stb to the next fall_stb is ceil(D/2) cycles. The interval from fall_stb to the next rise_stb is floor(D/2) cycles. For an odd D, the high half is therefore the longer one.
- R9: A change of presc or legacy_mode while run stays high leaves the period unchanged. The new value applies after run goes low and then high again.
- R10: rise_stb and fall_stb are never high in the same cycle. sclk_lvl is high in the cycle after rise_stb and low in the cycle after fall_stb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High while a transfer is in progress; a rising level starts a new count |
| presc | input | 8 | Packed prescale byte |
| legacy_mode | input | 1 | 1 selects the offset-coded legacy encoding, 0 the extended encoding |
| rise_stb | output | 1 | One-cycle strobe at each serial clock rising edge |
| fall_stb | output | 1 | One-cycle strobe at each serial clock falling edge |
| sclk_lvl | output | 1 | Current serial clock level (high during the high half) |

## Verification
The hardest situation to reach from the ports is a prescale change that lands while the sequencer is mid-period. The old divisor must keep governing the edges until a fresh start. The stimulus starts a short divisor and waits for the first rise strobe. It then rewrites the byte to a longer divisor and measures the following halves. Finally it drops run for two cycles, raises it again, and confirms that the new halves appear only then. Divisors of 2 and 3 are also driven, because there the strobes fall on consecutive cycles and the unequal halves are just one cycle long.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    localparam int PRESC_W  = 8;
    localparam int MANT_W   = 4;
    localparam int EXP_W    = 3;
    localparam int LEG_W    = 5;
    localparam int DIV_W    = MANT_W + (1 << EXP_W) - 1;
    localparam int MAX_DIV  = ((1 << MANT_W) - 1) << ((1 << EXP_W) - 1);
    localparam int MAX_HALF = (MAX_DIV + 1) / 2;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        div_t hi;
        div_t lo;
    } halves_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOW_HALF  = 2'd1,
        ST_HIGH_HALF = 2'd2
    } sclk_state_e;

endpackage

// File: rtl/spi_presc_decode.sv
module spi_presc_decode
    import spi_presc_pkg::*;
#(
    parameter int  P_W       = PRESC_W,
    parameter int  M_W       = MANT_W,
    parameter int  E_W       = EXP_W,
    parameter int  L_W       = LEG_W,
    parameter int  D_W       = DIV_W,
    parameter bit  LEGACY_EN = 1'b1
) (
    input  logic [P_W-1:0] presc,
    input  logic           legacy_mode,
    output logic [D_W-1:0] divisor
);

    localparam int EXP_LO_BIT  = M_W;
    localparam int EXP_HI_BASE = P_W - (E_W - 1);
    localparam logic [L_W-1:0] LEG_OFFSET = L_W'(1 << (L_W - 1));
    localparam logic [L_W-1:0] LEG_MIN_F  = LEG_OFFSET + L_W'(2);

    logic [M_W-1:0] mant;
    logic [M_W-1:0] mant_eff;
    logic [E_W-1:0] expo;
    logic [D_W-1:0] ext_raw;
    logic [D_W-1:0] ext_div;
    logic [D_W-1:0] leg_div;
    logic           unused_reserved;

    assign mant     = presc[M_W-1:0];
    assign mant_eff = (mant == '0) ? M_W'(1) : mant;
    assign expo     = {presc[P_W-1:EXP_HI_BASE], presc[EXP_LO_BIT]};
    assign ext_raw  = D_W'(mant_eff) << expo;
    assign ext_div  = (ext_raw < D_W'(2)) ? D_W'(2) : ext_raw;
    assign unused_reserved = ^presc[EXP_HI_BASE-1:EXP_LO_BIT+1];

    generate
        if (LEGACY_EN) begin : g_legacy
            logic [L_W-1:0] fld;
            assign fld     = presc[L_W-1:0];
            assign leg_div = (fld < LEG_MIN_F) ? D_W'(4)
                                               : (D_W'(fld - LEG_OFFSET) << 1);
        end else begin : g_no_legacy
            assign leg_div = ext_div;
        end
    endgenerate

    assign divisor = legacy_mode ? leg_div : ext_div;

endmodule

// File: rtl/spi_presc_split.sv
module spi_presc_split
    import spi_presc_pkg::*;
(
    input  div_t    divisor,
    output halves_t halves
);

    always_comb begin
        halves.lo = divisor >> 1;
        halves.hi = divisor - halves.lo;
    end

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
    import spi_presc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    input  logic               legacy_mode,
    output logic               rise_stb,
    output logic               fall_stb,
    output logic               sclk_lvl
);

    div_t        divisor;
    halves_t     halves;
    sclk_state_e state_q, state_d;
    div_t        cnt_q, cnt_d;
    div_t        hi_q, hi_d;
    div_t        lo_q, lo_d;

    spi_presc_decode #(
        .P_W       (PRESC_W),
        .M_W       (MANT_W),
        .E_W       (EXP_W),
        .L_W       (LEG_W),
        .D_W       (DIV_W),
        .LEGACY_EN (1'b1)
    ) u_decode (
        .presc       (presc),
        .legacy_mode (legacy_mode),
        .divisor     (divisor)
    );

    spi_presc_split u_split (
        .divisor (divisor),
        .halves  (halves)
    );

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hi_d    = hi_q;
        lo_d    = lo_q;
        if (!run) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_LOW_HALF;
                    hi_d    = halves.hi;
                    lo_d    = halves.lo;
                    cnt_d   = halves.lo - DIV_W'(1);
                end
                ST_LOW_HALF: begin
                    if (cnt_q == '0) begin
                        state_d = ST_HIGH_HALF;
                        cnt_d   = hi_q - DIV_W'(1);
                    end else begin
                        cnt_d   = cnt_q - DIV_W'(1);
                    end
                end
                ST_HIGH_HALF: begin
                    if (cnt_q == '0) begin
                        state_d = ST_LOW_HALF;
                        cnt_d   = lo_q - DIV_W'(1);
                    end else begin
                        cnt_d   = cnt_q - DIV_W'(1);
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hi_q    <= DIV_W'(1);
            lo_q    <= DIV_W'(1);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
        end
    end

    // Outputs
    always_comb begin
        rise_stb = run && (state_q == ST_LOW_HALF)  && (cnt_q == '0);
        fall_stb = run && (state_q == ST_HIGH_HALF) && (cnt_q == '0);
        sclk_lvl = (state_q == ST_HIGH_HALF);
    end

endmodule

// File: rtl/spi_presc_checker.sv
module spi_presc_checker
    import spi_presc_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic rise_stb,
    input logic fall_stb,
    input logic sclk_lvl
);

    localparam int GAP_W = DIV_W + 1;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (!run || rise_stb || fall_stb) begin
            gap_q <= '0;
        end else if (gap_q < GAP_W'(MAX_HALF + 1)) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    // R6: no strobes while run is low
    a_r6_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!rise_stb && !fall_stb));

    // R6: clock returns low one cycle after stopping
    a_r6_level_low_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk_lvl);

    // R10: strobes are mutually exclusive
    a_r10_exclusive_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    // R10: level follows the rise strobe
    a_r10_level_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> sclk_lvl);

    // R10: level follows the fall strobe
    a_r10_level_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !sclk_lvl);

    // R10: level moves only on a strobe or a stop
    a_r10_level_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_lvl != $past(sclk_lvl)) |-> ($past(rise_stb) || $past(fall_stb) || !$past(run)));

    // R8: no half period exceeds the largest possible half
    a_r8_half_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (gap_q <= GAP_W'(MAX_HALF)));

endmodule

bind spi_sclk_prescaler spi_presc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .sclk_lvl (sclk_lvl)
);

// File: tb/spi_sclk_prescaler_tb.sv
module spi_sclk_prescaler_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] presc = 8'h00;
    logic       legacy_mode = 1'b0;
    logic       rise_stb;
    logic       fall_stb;
    logic       sclk_lvl;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    localparam int WAIT_LIMIT = 4000;

    always #2 clk = ~clk;

    spi_sclk_prescaler u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .presc       (presc),
        .legacy_mode (legacy_mode),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .sclk_lvl    (sclk_lvl)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            failures = failures + 1;
            $display("FAIL watchdog: act=%0d cycles exp<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Count negedges until the requested strobe is seen
    task automatic wait_stb(input bit want_rise, output int n);
        n = 0;
        for (int i = 0; i < WAIT_LIMIT; i++) begin
            @(negedge clk);
            n = n + 1;
            if (want_rise ? rise_stb : fall_stb) break;
        end
    endtask

    task automatic stop_and_check(input string req);
        run = 1'b0;
        #1;
        chk({req, "/R6 strobes off"}, int'(rise_stb | fall_stb), 0);
        @(negedge clk);
        chk({req, "/R6 level low"}, int'(sclk_lvl), 0);
        @(negedge clk);
    endtask

    // Start a transfer with the given config and measure its halves
    task automatic run_case(input string req, input logic [7:0] p,
                            input bit leg, input int div);
        int n;
        int lo_exp;
        int hi_exp;
        lo_exp = div / 2;
        hi_exp = div - lo_exp;
        @(negedge clk);
        presc = p;
        legacy_mode = leg;
        run = 1'b1;
        wait_stb(1'b1, n);
        chk({req, "/R7 first rise"}, n, lo_exp);
        wait_stb(1'b0, n);
        chk({req, "/R8 high half"}, n, hi_exp);
        wait_stb(1'b1, n);
        chk({req, "/R8 low half"}, n, lo_exp);
        stop_and_check(req);
    endtask

    task automatic t_reset;
        #1;
        chk("R1 rise", int'(rise_stb), 0);
        chk("R1 fall", int'(fall_stb), 0);
        chk("R1 level", int'(sclk_lvl), 0);
    endtask

    task automatic t_extended;
        run_case("R2 0x15", 8'h15, 1'b0, 10);
        run_case("R2 0x0A", 8'h0A, 1'b0, 10);
        run_case("R2 0x2A bit5", 8'h2A, 1'b0, 10);
        run_case("R2 0xC2", 8'hC2, 1'b0, 128);
        run_case("R2 0x03 odd", 8'h03, 1'b0, 3);
        run_case("R2 0x40", 8'h40, 1'b0, 4);
        run_case("R2 0xDF max", 8'hDF, 1'b0, 1920);
    endtask

    task automatic t_mant_zero;
        run_case("R3 0x00", 8'h00, 1'b0, 2);
        run_case("R3 0x10", 8'h10, 1'b0, 2);
        run_case("R3 0x20", 8'h20, 1'b0, 2);
    endtask

    task automatic t_legacy;
        run_case("R4 0x1F", 8'h1F, 1'b1, 30);
        run_case("R4 0x17", 8'h17, 1'b1, 14);
        run_case("R4 0xF7 upper", 8'hF7, 1'b1, 14);
        run_case("R4 0x13", 8'h13, 1'b1, 6);
    endtask

    task automatic t_legacy_clamp;
        run_case("R5 0x12", 8'h12, 1'b1, 4);
        run_case("R5 0x11", 8'h11, 1'b1, 4);
        run_case("R5 0x05", 8'h05, 1'b1, 4);
    endtask

    task automatic t_idle_quiet;
        int seen;
        seen = 0;
        @(negedge clk);
        presc = 8'h01;
        legacy_mode = 1'b0;
        run = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rise_stb || fall_stb || sclk_lvl) seen = seen + 1;
        end
        chk("R6 idle quiet", seen, 0);
    endtask

    task automatic t_midrun_change;
        int n;
        @(negedge clk);
        presc = 8'h06;
        legacy_mode = 1'b0;
        run = 1'b1;
        wait_stb(1'b1, n);
        chk("R9 first rise old", n, 3);
        presc = 8'h0F;
        wait_stb(1'b0, n);
        chk("R9 high half old", n, 3);
        legacy_mode = 1'b1;
        wait_stb(1'b1, n);
        chk("R9 low half old", n, 3);
        legacy_mode = 1'b0;
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        run = 1'b1;
        wait_stb(1'b1, n);
        chk("R9 first rise new", n, 7);
        wait_stb(1'b0, n);
        chk("R9 high half new", n, 8);
        stop_and_check("R9");
    endtask

    task automatic t_level_tracking;
        int n;
        @(negedge clk);
        presc = 8'h05;
        legacy_mode = 1'b0;
        run = 1'b1;
        wait_stb(1'b1, n);
        chk("R10 no fall with rise", int'(fall_stb), 0);
        @(negedge clk);
        chk("R10 level high after rise", int'(sclk_lvl), 1);
        wait_stb(1'b0, n);
        chk("R10 no rise with fall", int'(rise_stb), 0);
        @(negedge clk);
        chk("R10 level low after fall", int'(sclk_lvl), 0);
        stop_and_check("R10");
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_quiet();
        t_extended();
        t_mant_zero();
        t_legacy();
        t_legacy_clamp();
        t_midrun_change();
        t_level_tracking();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule